// File: doc/BRIEF.md
# Pipelined Address Bus Arbiter

This block decides which of several requesters owns a shared, split-transaction address bus. It serves seven masters. Indices 0 to 2 are external devices, each with a request input and a grant output. Indices 3 to 6 are on-chip agents: the processor core, the communications engine, the memory refresh logic and the bus bridge. Each on-chip agent drives a request and a priority level. The levels of the external devices come from a configuration input. The grant goes to the active request with the highest level.

A grant lets a master open an address tenure by pulsing its transfer start. All grants then stay low until that master raises address acknowledge. The next grant appears in the cycle that follows the acknowledge. The arbiter counts the data tenures that have been acknowledged but not yet completed. This allows the bus to be handed on before the data phase ends, but never with more than a configurable number of data tenures still pending. When nobody is requesting, the grant can rest on a chosen parked master. That master can then start without first raising a request. A mode input is captured during reset and decides whether the arbiter drives grants at all or leaves arbitration to an outside device.

Top module: `addr_bus_arbiter`

## Requirements
- R1: Master index i maps to grant bit i, with external masters at indices 0 to 2 and on-chip agents at 3 to 6. After reset all grants are low, no tenure is open and the pending count is zero.
- R2: When requests are active and a grant is allowed, the grant goes to the requester with the largest 2-bit level. External master k takes bits [2k+1:2k] of `extLevelCfg`, and on-chip agent j takes bits [2j+1:2j] of `intLevel`.
- R3: Among active requesters with equal top level, the lowest index wins.
- R4: At most one grant bit is high in any cycle.
- R5: A tenure opens on a clock edge where `ts` is high, some grant is high and no tenure is open. All grants are low from the next cycle until the tenure closes. `ts` or `aack` outside those conditions is ignored.
- R6: On the edge that samples `aack` high during an open tenure, the tenure closes. If there is room in the pending count, the next grant is visible in the cycle right after that edge.
- R7: With no request active, the grant rests on master `parkSel` when `parkEn` is high and `parkSel` is below 7. Otherwise all grants are low.
- R8: A parked master may open a tenure with `ts` while its request is low.
- R9: An accepted `aack` adds one to the pending count, and `dataDone` removes one when the count is non-zero (both together leave it unchanged). While the count equals PIPE_DEPTH (default 2), all grants are low.
- R10: `useInternal` is captured while `rst_n` is low. If it was low, all grants stay low until the next reset, whatever it does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also the capture window for the mode |
| useInternal | input | 1 | High selects on-chip arbitration, sampled during reset |
| extReq | input | 3 | Requests of external masters 0 to 2 |
| extLevelCfg | input | 6 | 2-bit priority level per external master |
| intReq | input | 4 | Requests of on-chip agents (indices 3 to 6) |
| intLevel | input | 8 | 2-bit priority level per on-chip agent |
| parkEn | input | 1 | Enables bus parking |
| parkSel | input | 3 | Index of the parked master |
| ts | input | 1 | Transfer start from the granted master |
| aack | input | 1 | Address acknowledge closing the open tenure |
| dataDone | input | 1 | Completion of the oldest pending data tenure |
| extGnt | output | 3 | Grants to external masters |
| intGnt | output | 4 | Grants to on-chip agents |

## Verification
The bench builds the block with its default parameters: three external masters, four on-chip agents, 2-bit levels and a pipeline depth of two. With a depth of two, two back-to-back acknowledges without a completion fill the pending count within a few cycles, so the blocked-grant case, its release by `dataDone`, and a simultaneous acknowledge and completion are all reached in short directed runs. With seven masters and four levels, ties, parking on an index with no request, and an out-of-range park index are each one input setting away. A long run of random traffic then compares the grant bits with a behavioural model on every clock.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef struct packed {
    logic allowGrant;
    logic allowPark;
  } arbStrobe_t;
endpackage

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int N = 7,
  parameter int LVL_W = 2,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic [N*LVL_W-1:0]   levels,
  input  logic [IDX_W-1:0]     parkSel,
  input  arbStrobe_t           strobe,
  output logic [N-1:0]         gnt
);
  localparam logic [IDX_W-1:0] N_V = IDX_W'(N);

  logic [LVL_W-1:0] lvl [N];
  logic [IDX_W-1:0] bestIdx;
  logic [LVL_W-1:0] bestLvl;
  logic             found;
  logic [N-1:0]     winVec;
  logic [N-1:0]     parkVec;
  logic [N-1:0]     gntNext;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign lvl[g] = levels[g*LVL_W +: LVL_W];
  end

  // strict compare in ascending index order keeps the lowest index on ties
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestLvl = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || lvl[i] > bestLvl)) begin
        found   = 1'b1;
        bestIdx = IDX_W'(i);
        bestLvl = lvl[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      winVec[i]  = found && (bestIdx == IDX_W'(i));
      parkVec[i] = (parkSel < N_V) && (parkSel == IDX_W'(i));
    end
  end

  always_comb begin
    if (!strobe.allowGrant) gntNext = '0;
    else if (found)         gntNext = winVec;
    else if (strobe.allowPark) gntNext = parkVec;
    else                    gntNext = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt <= '0;
    else        gnt <= gntNext;
  end

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int PIPE_DEPTH = 2,
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              useInternal,
  input  logic              ts,
  input  logic              aack,
  input  logic              dataDone,
  input  logic              gntAny,
  input  logic              parkEn,
  output arbStrobe_t        strobe,
  output logic              tenureOpen,
  output logic [PEND_W-1:0] pendCnt,
  output logic              modeOn
);
  localparam logic [PEND_W-1:0] DEPTH_V = PEND_W'(PIPE_DEPTH);

  logic              startEvt;
  logic              ackEvt;
  logic              doneEvt;
  logic              openNext;
  logic [PEND_W-1:0] pendNext;

  // mode capture runs only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) modeOn <= useInternal;
  end

  assign startEvt = modeOn && !tenureOpen && ts && gntAny;
  assign ackEvt   = tenureOpen && aack;
  assign doneEvt  = dataDone && (pendCnt != '0);

  always_comb begin
    pendNext = pendCnt + PEND_W'(ackEvt) - PEND_W'(doneEvt);
    if (startEvt)    openNext = 1'b1;
    else if (ackEvt) openNext = 1'b0;
    else             openNext = tenureOpen;
    strobe.allowGrant = modeOn && !openNext && (pendNext < DEPTH_V);
    strobe.allowPark  = strobe.allowGrant && parkEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tenureOpen <= 1'b0;
      pendCnt    <= '0;
    end else begin
      tenureOpen <= openNext;
      pendCnt    <= pendNext;
    end
  end

  // R9
  pend_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pendCnt <= DEPTH_V);

  // R5
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tenureOpen && aack && !dataDone) |=> $stable(pendCnt));
endmodule

// File: rtl/addr_bus_arbiter.sv
module addr_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_EXT = 3,
  parameter int N_INT = 4,
  parameter int LVL_W = 2,
  parameter int PIPE_DEPTH = 2,
  parameter int IDX_W = $clog2(N_EXT + N_INT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   useInternal,
  input  logic [N_EXT-1:0]       extReq,
  input  logic [N_EXT*LVL_W-1:0] extLevelCfg,
  input  logic [N_INT-1:0]       intReq,
  input  logic [N_INT*LVL_W-1:0] intLevel,
  input  logic                   parkEn,
  input  logic [IDX_W-1:0]       parkSel,
  input  logic                   ts,
  input  logic                   aack,
  input  logic                   dataDone,
  output logic [N_EXT-1:0]       extGnt,
  output logic [N_INT-1:0]       intGnt
);
  localparam int N = N_EXT + N_INT;
  localparam int PEND_W = $clog2(PIPE_DEPTH + 1);

  arbStrobe_t        strobe;
  logic [N-1:0]      gnt;
  logic              tenureOpen;
  logic [PEND_W-1:0] pendCnt;
  logic              modeOn;
  logic [N-1:0]      reqAll;

  assign reqAll = {intReq, extReq};

  arb_ctrl #(.PIPE_DEPTH(PIPE_DEPTH), .PEND_W(PEND_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .useInternal(useInternal), .ts(ts),
    .aack(aack), .dataDone(dataDone), .gntAny(|gnt), .parkEn(parkEn),
    .strobe(strobe), .tenureOpen(tenureOpen), .pendCnt(pendCnt),
    .modeOn(modeOn)
  );

  arb_pick #(.N(N), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(reqAll),
    .levels({intLevel, extLevelCfg}), .parkSel(parkSel),
    .strobe(strobe), .gnt(gnt)
  );

  assign extGnt = gnt[N_EXT-1:0];
  assign intGnt = gnt[N-1:N_EXT];

  // R5
  quiet_tenure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tenureOpen |-> (gnt == '0));

  // R6
  regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOn && tenureOpen && aack && (int'(pendCnt) + 1 < PIPE_DEPTH) && (|reqAll))
      |=> (|gnt));

  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pendCnt) == PIPE_DEPTH) |-> (gnt == '0));

  // R10
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !modeOn |-> (gnt == '0));
endmodule

// File: tb/addr_bus_arbiter_test.sv
`timescale 1ns/1ps
module addr_bus_arbiter_test;
  localparam int DEPTH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       useInternal = 1'b1;
  logic [2:0] extReq = '0;
  logic [5:0] extLevelCfg = '0;
  logic [3:0] intReq = '0;
  logic [7:0] intLevel = '0;
  logic       parkEn = 1'b0;
  logic [2:0] parkSel = '0;
  logic       ts = 1'b0;
  logic       aack = 1'b0;
  logic       dataDone = 1'b0;
  logic [2:0] extGnt;
  logic [3:0] intGnt;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curTag = "R1";

  bit mMode;
  bit mOpen;
  int mPend;
  int mGnt;

  addr_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .useInternal(useInternal),
    .extReq(extReq), .extLevelCfg(extLevelCfg), .intReq(intReq),
    .intLevel(intLevel), .parkEn(parkEn), .parkSel(parkSel), .ts(ts),
    .aack(aack), .dataDone(dataDone), .extGnt(extGnt), .intGnt(intGnt)
  );

  always #4 clk = ~clk;

  function automatic logic [6:0] gntVec();
    return {intGnt, extGnt};
  endfunction

  function automatic bit reqOf(int i);
    return (i < 3) ? extReq[i] : intReq[i-3];
  endfunction

  function automatic int lvlOf(int i);
    return (i < 3) ? int'(extLevelCfg[i*2 +: 2]) : int'(intLevel[(i-3)*2 +: 2]);
  endfunction

  function automatic logic [6:0] expVec();
    return (mGnt < 0) ? 7'd0 : (7'd1 << mGnt);
  endfunction

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grants=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock of the reference model, then compare after the edge
  task automatic step();
    bit start, ack, done, nOpen;
    int nPend, best, nGnt;
    start = mMode && !mOpen && ts && (mGnt >= 0);
    ack   = mOpen && aack;
    done  = dataDone && (mPend > 0);
    nPend = mPend + int'(ack) - int'(done);
    nOpen = start ? 1'b1 : (ack ? 1'b0 : mOpen);
    best = -1;
    for (int l = 3; l >= 0; l--)
      for (int i = 0; i < 7; i++)
        if (best < 0 && reqOf(i) && lvlOf(i) == l) best = i;
    if (!mMode || nOpen || nPend >= DEPTH) nGnt = -1;
    else if (best >= 0) nGnt = best;
    else if (parkEn && parkSel < 3'd7) nGnt = int'(parkSel);
    else nGnt = -1;
    @(posedge clk);
    #2;
    mOpen = nOpen;
    mPend = nPend;
    mGnt  = nGnt;
    chk(curTag, gntVec(), expVec());
  endtask

  task automatic doReset(bit mode);
    rst_n = 1'b0;
    useInternal = mode;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    mMode = mode;
    mOpen = 0;
    mPend = 0;
    mGnt  = -1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset(1'b1);
    chk("R1", gntVec(), 7'd0);

    curTag = "R7";
    parkEn = 1'b1; parkSel = 3'd4;
    step();
    chk("R7", gntVec(), 7'b0010000);
    parkSel = 3'd7;
    step();
    chk("R7", gntVec(), 7'd0);
    parkEn = 1'b0; parkSel = 3'd1;
    step();
    chk("R7", gntVec(), 7'd0);

    curTag = "R2";
    extReq = 3'b010; extLevelCfg = 6'b00_01_00;
    intReq = 4'b0100; intLevel = 8'b00_11_00_00;
    step();
    chk("R2", gntVec(), 7'b0100000);
    intLevel = 8'b00_00_00_00;
    step();
    chk("R2", gntVec(), 7'b0000010);

    curTag = "R3";
    extReq = 3'b100; extLevelCfg = 6'b10_00_00;
    intReq = 4'b0010; intLevel = 8'b00_00_10_00;
    step();
    chk("R3", gntVec(), 7'b0000100);

    curTag = "R5";
    ts = 1'b1;
    step();
    chk("R5", gntVec(), 7'd0);
    ts = 1'b0;
    step();
    step();
    chk("R5", gntVec(), 7'd0);
    curTag = "R6";
    aack = 1'b1;
    step();
    chk("R6", gntVec(), 7'b0000100);

    curTag = "R9";
    aack = 1'b0; ts = 1'b1;
    step();
    ts = 1'b0; aack = 1'b1;
    step();
    chk("R9", gntVec(), 7'd0);
    aack = 1'b0;
    step();
    step();
    chk("R9", gntVec(), 7'd0);
    dataDone = 1'b1;
    step();
    chk("R9", gntVec(), 7'b0000100);
    step();
    dataDone = 1'b0;

    curTag = "R8";
    extReq = '0; intReq = '0;
    parkEn = 1'b1; parkSel = 3'd0;
    step();
    chk("R8", gntVec(), 7'b0000001);
    ts = 1'b1;
    step();
    chk("R8", gntVec(), 7'd0);
    ts = 1'b0; aack = 1'b1;
    step();
    chk("R8", gntVec(), 7'b0000001);
    aack = 1'b0; dataDone = 1'b1;
    step();
    dataDone = 1'b0;

    curTag = "R9";
    ts = 1'b1; step();
    ts = 1'b0; aack = 1'b1; step();
    aack = 1'b0; ts = 1'b1; step();
    ts = 1'b0; aack = 1'b1; dataDone = 1'b1; step();
    chk("R9", gntVec(), 7'b0000001);
    aack = 1'b0; dataDone = 1'b0; ts = 1'b1; step();
    ts = 1'b0; aack = 1'b1; step();
    chk("R9", gntVec(), 7'd0);
    aack = 1'b0; dataDone = 1'b1; step();
    chk("R9", gntVec(), 7'b0000001);
    step();
    dataDone = 1'b0;

    curTag = "R4";
    for (int n = 0; n < 3000; n++) begin
      extReq      = 3'($urandom);
      intReq      = 4'($urandom);
      extLevelCfg = 6'($urandom);
      intLevel    = 8'($urandom);
      parkEn      = 1'($urandom);
      parkSel     = 3'($urandom);
      ts          = ($urandom % 10) < 3;
      aack        = ($urandom % 10) < 3;
      dataDone    = ($urandom % 10) < 3;
      step();
    end

    curTag = "R10";
    ts = 1'b0; aack = 1'b0; dataDone = 1'b0;
    extReq = 3'b111; intReq = 4'b1111;
    parkEn = 1'b1; parkSel = 3'd2;
    doReset(1'b0);
    chk("R10", gntVec(), 7'd0);
    repeat (4) step();
    useInternal = 1'b1;
    repeat (3) step();
    chk("R10", gntVec(), 7'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule